// File: doc/BRIEF.md
# Domain Power-Off and Bus Isolation Controller

This block sits at the edge of a switchable peripheral domain. It decides when the peripheral bus is cut off from the main processor bus. It keeps a power-off request that software can set but cannot withdraw, and it passes a power-down request to the always-on domain and returns the acknowledge. It also holds the enable of the latches that freeze the I/O pads.

Software writes four one-bit controls through separate write strobes:
- the disconnect request,
- the power-off request,
- the power-down request,
- the pad latch enable.

The always-on domain supplies a force-on level and a sequencer-run-enable level. Both levels are reported back in a two-bit status word. A disconnect takes effect through a two-stage pipeline. The power-off command to the power switch is raised only when the domain is isolated and not forced on. The domain power-up reset (`rst_n`) is the only event that clears the power-off request.

Top module: `pwr_iso_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0: `bus_isolate`, `disc_status`, `disc_ack`, `pwroff_req`, `pwroff_cmd`, `pd_ack`, `pd_busy` and `io_latch_en`. The exception is `aon_stat`, which follows its inputs.
- R2: The isolation term is 1 when the stored disconnect request is 1 and `force_on` is 0, or when `pd_ack` is 1. `bus_isolate` shows this term as it was two clock edges earlier. `disc_status` always equals `bus_isolate`.
- R3: While `force_on` is 1 and `pd_ack` is 0, the disconnect request has no effect: two edges later `bus_isolate` is 0.
- R4: `disc_ack` equals the stored disconnect request as it was two clock edges earlier, whatever `force_on` is.
- R5: A write with `off_wd`=1 sets `pwroff_req` at the next edge. A write with `off_wd`=0 leaves it unchanged. Only a low `rst_n` clears it.
- R6: `pwroff_cmd` is 1 exactly when `pwroff_req` is 1, `force_on` is 0 and `disc_status` is 1.
- R7: `pd_ack` equals the stored power-down request delayed by `ACK_DLY` clock edges (default 3).
- R8: `pd_busy` is 1 while the stored power-down request is 1 or `pd_ack` is 1. The domain is therefore still treated as powered down after the request is cleared, until the acknowledge drops.
- R9: `io_latch_en` takes `latch_wd` on a write. 1 means the pads are transparent and 0 means they hold their mode and output value. It resets to 0.
- R10: `aon_stat[1]` reflects `force_on` and `aon_stat[0]` reflects `seq_run_en`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Domain power-up reset, active low, asynchronous |
| disc_we | input | 1 | Write strobe for the disconnect request |
| disc_wd | input | 1 | Disconnect request value |
| off_we | input | 1 | Write strobe for the power-off request |
| off_wd | input | 1 | Power-off write data (only 1 has an effect) |
| pdn_we | input | 1 | Write strobe for the power-down request |
| pdn_wd | input | 1 | Power-down request value |
| latch_we | input | 1 | Write strobe for the pad latch enable |
| latch_wd | input | 1 | Pad latch value (1 transparent, 0 hold) |
| force_on | input | 1 | Force-on level from the always-on domain |
| seq_run_en | input | 1 | Sequencer run-enable level from the always-on domain |
| bus_isolate | output | 1 | Bus isolation control (1 isolates) |
| disc_status | output | 1 | Disconnected status |
| disc_ack | output | 1 | Acknowledge of the disconnect request |
| pwroff_req | output | 1 | Sticky power-off request |
| pwroff_cmd | output | 1 | Power-off command to the power switch |
| pd_ack | output | 1 | Power-down acknowledge |
| pd_busy | output | 1 | Domain must be treated as powered down |
| io_latch_en | output | 1 | Pad latch enable |
| aon_stat | output | 2 | {force_on, seq_run_en} |

## Verification
Random write strobes are mixed with slow toggles of `force_on`. This makes the disconnect request meet both force-on levels, which separates the override of R3 from the plain two-edge delay of R2 and R4. Power-down requests are toggled often enough that `pd_ack` overlaps periods with the disconnect request both off and on. This shows whether the acknowledge alone forces isolation and whether `pd_busy` spans the acknowledge tail. Power-off writes carry both data values, and a reset is pulsed every few hundred cycles. Together these show that a written 0 never clears the request and that only reset does.

// File: rtl/pwr_iso_ctrl.sv
module pwr_iso_ctrl #(
  parameter int ACK_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       disc_we,
  input  logic       disc_wd,
  input  logic       off_we,
  input  logic       off_wd,
  input  logic       pdn_we,
  input  logic       pdn_wd,
  input  logic       latch_we,
  input  logic       latch_wd,
  input  logic       force_on,
  input  logic       seq_run_en,
  output logic       bus_isolate,
  output logic       disc_status,
  output logic       disc_ack,
  output logic       pwroff_req,
  output logic       pwroff_cmd,
  output logic       pd_ack,
  output logic       pd_busy,
  output logic       io_latch_en,
  output logic [1:0] aon_stat
);

  logic               disc_q, pdn_q, latch_q, off_q;
  logic [1:0]         iso_pipe, ack_pipe;
  logic [ACK_DLY-1:0] pd_pipe;
  logic [ACK_DLY:0]   pd_next;
  logic               iso_term;

  assign iso_term = (disc_q & ~force_on) | pd_ack;
  assign pd_next  = {pd_pipe, pdn_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disc_q   <= 1'b0;
      pdn_q    <= 1'b0;
      latch_q  <= 1'b0;
      off_q    <= 1'b0;
      iso_pipe <= '0;
      ack_pipe <= '0;
      pd_pipe  <= '0;
    end else begin
      if (disc_we)  disc_q  <= disc_wd;
      if (pdn_we)   pdn_q   <= pdn_wd;
      if (latch_we) latch_q <= latch_wd;
      if (off_we && off_wd) off_q <= 1'b1;
      iso_pipe <= {iso_pipe[0], iso_term};
      ack_pipe <= {ack_pipe[0], disc_q};
      pd_pipe  <= pd_next[ACK_DLY-1:0];
    end
  end

  assign bus_isolate = iso_pipe[1];
  assign disc_status = iso_pipe[1];
  assign disc_ack    = ack_pipe[1];
  assign pwroff_req  = off_q;
  assign pwroff_cmd  = off_q & ~force_on & iso_pipe[1];
  assign pd_ack      = pd_pipe[ACK_DLY-1];
  assign pd_busy     = pdn_q | pd_ack;
  assign io_latch_en = latch_q;
  assign aon_stat    = {force_on, seq_run_en};

endmodule

module pwr_iso_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_on,
  input logic       seq_run_en,
  input logic       bus_isolate,
  input logic       disc_status,
  input logic       pwroff_req,
  input logic       pwroff_cmd,
  input logic       pd_ack,
  input logic       pd_busy,
  input logic [1:0] aon_stat
);

  a_r2_ack_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> ##2 bus_isolate);

  a_r2_status_match: assert property (@(posedge clk) disable iff (!rst_n)
    disc_status == bus_isolate);

  a_r3_force_connects: assert property (@(posedge clk) disable iff (!rst_n)
    (force_on && !pd_ack) |-> ##2 !bus_isolate);

  a_r5_sticky_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |=> pwroff_req);

  a_r6_cmd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_cmd |-> (pwroff_req && !force_on && disc_status));

  a_r8_busy_covers_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> pd_busy);

  a_r10_stat_levels: assert property (@(posedge clk) disable iff (!rst_n)
    aon_stat == {force_on, seq_run_en});

endmodule

bind pwr_iso_ctrl pwr_iso_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .force_on(force_on), .seq_run_en(seq_run_en),
  .bus_isolate(bus_isolate), .disc_status(disc_status), .pwroff_req(pwroff_req),
  .pwroff_cmd(pwroff_cmd), .pd_ack(pd_ack), .pd_busy(pd_busy), .aon_stat(aon_stat)
);

// File: tb/pwr_iso_ctrl_bench.sv
module pwr_iso_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DLY   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disc_we = 0, disc_wd = 0, off_we = 0, off_wd = 0, pdn_we = 0, pdn_wd = 0;
  logic latch_we = 0, latch_wd = 0, force_on = 0, seq_run_en = 0;
  logic bus_isolate, disc_status, disc_ack, pwroff_req, pwroff_cmd;
  logic pd_ack, pd_busy, io_latch_en;
  logic [1:0] aon_stat;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_iso_ctrl #(.ACK_DLY(DLY)) u_pwr_iso_ctrl (
    .clk(clk), .rst_n(rst_n), .disc_we(disc_we), .disc_wd(disc_wd),
    .off_we(off_we), .off_wd(off_wd), .pdn_we(pdn_we), .pdn_wd(pdn_wd),
    .latch_we(latch_we), .latch_wd(latch_wd), .force_on(force_on),
    .seq_run_en(seq_run_en), .bus_isolate(bus_isolate), .disc_status(disc_status),
    .disc_ack(disc_ack), .pwroff_req(pwroff_req), .pwroff_cmd(pwroff_cmd),
    .pd_ack(pd_ack), .pd_busy(pd_busy), .io_latch_en(io_latch_en), .aon_stat(aon_stat)
  );

  // reference state built from the requirements
  logic m_dreq, m_off, m_pdreq, m_latch;
  logic [1:0] m_iso, m_ack;
  logic [DLY-1:0] m_pd;

  function automatic logic exp_pd_ack();
    return m_pd[DLY-1];
  endfunction

  function automatic logic exp_cmd();
    return m_off & ~force_on & m_iso[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dreq <= 0; m_off <= 0; m_pdreq <= 0; m_latch <= 0;
      m_iso <= 0; m_ack <= 0; m_pd <= 0;
    end else begin
      if (disc_we)  m_dreq  <= disc_wd;
      if (pdn_we)   m_pdreq <= pdn_wd;
      if (latch_we) m_latch <= latch_wd;
      if (off_we && off_wd) m_off <= 1'b1;
      m_iso <= {m_iso[0], (m_dreq & ~force_on) | exp_pd_ack()};
      m_ack <= {m_ack[0], m_dreq};
      for (int i = DLY-1; i > 0; i--) m_pd[i] <= m_pd[i-1];
      m_pd[0] <= m_pdreq;
    end
  end

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2 bus_isolate", bus_isolate, m_iso[1]);
    check("R2 disc_status", disc_status, m_iso[1]);
    check("R4 disc_ack", disc_ack, m_ack[1]);
    check("R5 pwroff_req", pwroff_req, m_off);
    check("R6 pwroff_cmd", pwroff_cmd, exp_cmd());
    check("R7 pd_ack", pd_ack, exp_pd_ack());
    check("R8 pd_busy", pd_busy, m_pdreq | exp_pd_ack());
    check("R9 io_latch_en", io_latch_en, m_latch);
    check("R10 aon_stat", aon_stat, {force_on, seq_run_en});
  endtask

  task automatic clear_we();
    disc_we = 0; off_we = 0; pdn_we = 0; latch_we = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state with inputs low
    check("R1 reset outputs",
          {bus_isolate | disc_status | disc_ack | pwroff_req | pwroff_cmd, pd_ack | pd_busy | io_latch_en},
          2'b00);
    rst_n = 1;
    @(negedge clk); check_all();

    // directed R3: disconnect requested while forced on
    force_on = 1; disc_we = 1; disc_wd = 1;
    @(negedge clk); clear_we();
    repeat (3) begin @(negedge clk); check_all(); end
    check("R3 forced connect", bus_isolate, 1'b0);
    check("R4 ack despite force", disc_ack, 1'b1);
    force_on = 0;
    repeat (3) begin @(negedge clk); check_all(); end
    check("R2 isolate after force drop", bus_isolate, 1'b1);

    // directed R5/R6: write 1 then write 0
    off_we = 1; off_wd = 1; @(negedge clk); clear_we();
    check("R6 cmd raised", pwroff_cmd, 1'b1);
    off_we = 1; off_wd = 0; @(negedge clk); clear_we();
    check("R5 write zero ignored", pwroff_req, 1'b1);
    force_on = 1; @(negedge clk);
    check("R6 cmd blocked by force", pwroff_cmd, 1'b0);
    force_on = 0;

    // directed R7/R8: pd_ack forces isolation and busy tail
    disc_we = 1; disc_wd = 0; pdn_we = 1; pdn_wd = 1;
    @(negedge clk); clear_we();
    repeat (DLY + 2) begin @(negedge clk); check_all(); end
    check("R2 ack isolates", bus_isolate, 1'b1);
    pdn_we = 1; pdn_wd = 0; @(negedge clk); clear_we();
    check("R8 busy tail", pd_busy, 1'b1);
    repeat (DLY + 1) begin @(negedge clk); check_all(); end
    check("R8 busy released", pd_busy, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      check_all();
      if (n % 500 == 499) begin
        rst_n = 0; clear_we();
        @(negedge clk);
        check("R5 reset clears", pwroff_req, 1'b0);
        check("R1 reset isolate", bus_isolate, 1'b0);
        rst_n = 1;
      end else begin
        disc_we  = ($urandom % 4) == 0;  disc_wd  = $urandom;
        off_we   = ($urandom % 64) == 0; off_wd   = $urandom;
        pdn_we   = ($urandom % 8) == 0;  pdn_wd   = $urandom;
        latch_we = ($urandom % 8) == 0;  latch_wd = $urandom;
        if (($urandom % 16) == 0) force_on = ~force_on;
        seq_run_en = $urandom;
      end
      @(negedge clk);
    end
    check_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule